// File: doc/BRIEF.md
# Stereo Ramped Digital Volume

This block scales a two-channel stream of 24-bit signed samples. A word strobe marks each new sample pair. Each channel has its own 8-bit attenuation code. Code 00h gives the largest gain, +24 dB. Each code step below it takes away half a decibel, so code 20h sits near +8 dB, code 30h is unity gain, and code FEh is -103 dB. Code FFh silences the channel.

The gain actually applied never jumps to a newly written code. Each channel keeps an applied code that walks one step at a time toward its volume input. It waits a fixed number of word strobes between steps. That number is chosen so that a walk across the whole code range finishes inside a bounded window of word periods. A mode input selects a ramp four times slower. The volume inputs may change at any time while audio is flowing. Results come out on registered outputs one clock after the strobe and are clamped to the 24-bit range.

Top module: `stereo_ramp_vol`

## Requirements
- R1: For an applied code c below FFh, each output equals floor(x * M[c mod 12] / 2^(11 + c div 12)), where M[r] = round(32768 * 2^(-r/12)). This takes 6 dB as an exact doubling, so code 00h is a gain of 16 (+24 dB) and code 30h is a gain of 1.
- R2: Applied code FFh forces the output of that channel to 0 for any input.
- R3: Any result above 8388607 is clamped to 8388607, and any result below -8388608 is clamped to -8388608.
- R4: While rst_n is low, both applied codes read 30h (0 dB), both outputs read 0 and out_vld is low.
- R5: out_vld is high exactly in the clock after a cycle with fs_stb high. The outputs then carry the input scaled by the applied code that was in force before that strobe. Without a strobe, the outputs and the applied codes hold.
- R6: The applied code changes only on a strobe, by exactly one code, and in the direction of that channel's volume input.
- R7: While a channel's applied code differs from its volume input, a step happens on every IV-th strobe, counted from the strobe at which the difference was first seen. IV is 3 in normal mode (floor of 912/255) and 12 with slow_ramp high. A full-range change therefore takes 765 strobes (at most 912), or 3060 strobes in slow mode (at most 3648).
- R8: The left and right channels ramp and scale independently of each other.
- R9: When the volume input changes in the middle of a ramp, the applied code turns and walks toward the new value.
- R10: Once the applied code equals the volume input, it stays there and the step counter holds at its start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| fs_stb | input | 1 | One-cycle word strobe; one sample per channel |
| slow_ramp | input | 1 | 1 selects the four-times-longer ramp |
| vol_l | input | 8 | Left volume code |
| vol_r | input | 8 | Right volume code |
| in_l | input | 24 | Left input sample, signed |
| in_r | input | 24 | Right input sample, signed |
| out_l | output | 24 | Left scaled, clamped sample |
| out_r | output | 24 | Right scaled, clamped sample |
| out_vld | output | 1 | High the cycle after a strobe |
| cur_l | output | 8 | Left applied code |
| cur_r | output | 8 | Right applied code |

## Verification
A wrong applied code or a wrong step counter first shows up as a wrong value on cur_l or cur_r. It appears at the first strobe where the step timing differs from the IV rule. A wrong gain then shows in the very next output word. The bench sweeps one channel through every code from 00h to FFh and alternates full-scale, small and sign-flipping inputs along the way. A wrong mantissa entry, octave shift or clamp therefore turns into a wrong sample within one strobe of that code being applied. Slow mode, a reversal in mid-ramp and idle gaps between strobes check the timing of the applied code against an independent model, one strobe at a time.

// File: rtl/stereo_ramp_vol.sv
module stereo_ramp_vol #(
  parameter int DW        = 24,
  parameter int VW        = 8,
  parameter int RAMP_MAX  = 912,
  parameter int SLOW_MUL  = 4,
  parameter int UNITY     = 48
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 fs_stb,
  input  logic                 slow_ramp,
  input  logic [VW-1:0]        vol_l,
  input  logic [VW-1:0]        vol_r,
  input  logic signed [DW-1:0] in_l,
  input  logic signed [DW-1:0] in_r,
  output logic signed [DW-1:0] out_l,
  output logic signed [DW-1:0] out_r,
  output logic                 out_vld,
  output logic [VW-1:0]        cur_l,
  output logic [VW-1:0]        cur_r
);
  localparam int MFB     = 15;
  localparam int HEADOCT = 4;
  localparam int BASE_SH = MFB - HEADOCT;
  localparam int MUTE    = (1 << VW) - 1;
  localparam int IV      = RAMP_MAX / MUTE;
  localparam int IV_SLOW = IV * SLOW_MUL;
  localparam int CW      = $clog2(IV_SLOW + 1);
  localparam int PW      = DW + MFB + 2;
  localparam logic signed [PW-1:0] HI = {{(PW-DW+1){1'b0}}, {(DW-1){1'b1}}};
  localparam logic signed [PW-1:0] LO = {{(PW-DW+1){1'b1}}, {(DW-1){1'b0}}};

  function automatic logic [MFB:0] mant(input logic [3:0] r);
    case (r)
      4'd1:    mant = 16'd30929;
      4'd2:    mant = 16'd29193;
      4'd3:    mant = 16'd27554;
      4'd4:    mant = 16'd26008;
      4'd5:    mant = 16'd24548;
      4'd6:    mant = 16'd23170;
      4'd7:    mant = 16'd21870;
      4'd8:    mant = 16'd20643;
      4'd9:    mant = 16'd19484;
      4'd10:   mant = 16'd18390;
      4'd11:   mant = 16'd17358;
      default: mant = 16'd32768;
    endcase
  endfunction

  function automatic logic signed [DW-1:0] scale(input logic signed [DW-1:0] x,
                                                 input logic [VW-1:0] c);
    logic [VW-1:0]          q;
    logic [3:0]             r;
    logic signed [PW-1:0]   p;
    logic signed [PW-1:0]   s;
    q = c / VW'(12);
    r = 4'(c % VW'(12));
    p = {{(PW-DW){x[DW-1]}}, x} * $signed({{(PW-MFB-1){1'b0}}, mant(r)});
    s = p >>> (VW'(BASE_SH) + q);
    if (c == VW'(MUTE))  scale = '0;
    else if (s > HI)     scale = HI[DW-1:0];
    else if (s < LO)     scale = LO[DW-1:0];
    else                 scale = s[DW-1:0];
  endfunction

  logic [CW-1:0]        ivm1;
  logic [VW-1:0]        tgt_v [2];
  logic signed [DW-1:0] x_v   [2];
  logic [VW-1:0]        cur_v [2];
  logic signed [DW-1:0] y_v   [2];

  assign ivm1     = slow_ramp ? CW'(IV_SLOW - 1) : CW'(IV - 1);
  assign tgt_v[0] = vol_l;
  assign tgt_v[1] = vol_r;
  assign x_v[0]   = in_l;
  assign x_v[1]   = in_r;
  assign cur_l    = cur_v[0];
  assign cur_r    = cur_v[1];
  assign out_l    = y_v[0];
  assign out_r    = y_v[1];

  for (genvar ch = 0; ch < 2; ch++) begin : g_ch
    logic [VW-1:0]        cur;
    logic [CW-1:0]        cnt;
    logic signed [DW-1:0] y;

    always_ff @(posedge clk) begin
      if (!rst_n) begin
        cur <= VW'(UNITY);
        cnt <= '0;
        y   <= '0;
      end else if (fs_stb) begin
        y <= scale(x_v[ch], cur);
        if (cur == tgt_v[ch]) begin
          cnt <= '0;
        end else if (cnt >= ivm1) begin
          cnt <= '0;
          cur <= (cur < tgt_v[ch]) ? cur + 1'b1 : cur - 1'b1;
        end else begin
          cnt <= cnt + 1'b1;
        end
      end
    end

    assign cur_v[ch] = cur;
    assign y_v[ch]   = y;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) out_vld <= 1'b0;
    else        out_vld <= fs_stb;
  end
endmodule

// File: rtl/stereo_ramp_vol_chk.sv
module stereo_ramp_vol_chk #(
  parameter int DW = 24,
  parameter int VW = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 fs_stb,
  input logic [VW-1:0]        vol_l,
  input logic [VW-1:0]        vol_r,
  input logic signed [DW-1:0] out_l,
  input logic signed [DW-1:0] out_r,
  input logic                 out_vld,
  input logic [VW-1:0]        cur_l,
  input logic [VW-1:0]        cur_r
);
  localparam logic [VW-1:0] MUTEC = '1;

  a_r5_vld_rise: assert property (@(posedge clk) disable iff (!rst_n)
    fs_stb |=> out_vld);
  a_r5_vld_fall: assert property (@(posedge clk) disable iff (!rst_n)
    !fs_stb |=> !out_vld);
  a_r5_out_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !fs_stb |=> ($stable(out_l) && $stable(out_r)));

  a_r6_only_on_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !fs_stb |=> ($stable(cur_l) && $stable(cur_r)));
  a_r6_unit_step_l: assert property (@(posedge clk) disable iff (!rst_n)
    fs_stb |=> (cur_l == $past(cur_l)) || (cur_l == $past(cur_l) + 1'b1)
               || ($past(cur_l) == cur_l + 1'b1));
  a_r6_unit_step_r: assert property (@(posedge clk) disable iff (!rst_n)
    fs_stb |=> (cur_r == $past(cur_r)) || (cur_r == $past(cur_r) + 1'b1)
               || ($past(cur_r) == cur_r + 1'b1));
  a_r6_toward_up_l: assert property (@(posedge clk) disable iff (!rst_n)
    (fs_stb && cur_l < vol_l) |=> cur_l >= $past(cur_l));
  a_r6_toward_dn_l: assert property (@(posedge clk) disable iff (!rst_n)
    (fs_stb && cur_l > vol_l) |=> cur_l <= $past(cur_l));

  a_r10_hold_l: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_l == vol_l) |=> cur_l == $past(cur_l));
  a_r10_hold_r: assert property (@(posedge clk) disable iff (!rst_n)
    (cur_r == vol_r) |=> cur_r == $past(cur_r));

  a_r2_mute_l: assert property (@(posedge clk) disable iff (!rst_n)
    (fs_stb && cur_l == MUTEC) |=> out_l == '0);
  a_r2_mute_r: assert property (@(posedge clk) disable iff (!rst_n)
    (fs_stb && cur_r == MUTEC) |=> out_r == '0);
endmodule

bind stereo_ramp_vol stereo_ramp_vol_chk #(.DW(DW), .VW(VW)) u_chk (
  .clk(clk), .rst_n(rst_n), .fs_stb(fs_stb), .vol_l(vol_l), .vol_r(vol_r),
  .out_l(out_l), .out_r(out_r), .out_vld(out_vld), .cur_l(cur_l), .cur_r(cur_r)
);

// File: tb/stereo_ramp_vol_tb.sv
module stereo_ramp_vol_tb_top;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic fs_stb = 1'b0;
  logic slow_ramp = 1'b0;
  logic [7:0] vol_l = 8'd48, vol_r = 8'd48;
  logic signed [23:0] in_l = '0, in_r = '0;
  logic signed [23:0] out_l, out_r;
  logic out_vld;
  logic [7:0] cur_l, cur_r;

  int total = 0, bad = 0;
  int ecur [2];
  int ecnt [2];
  int kidx = 0;

  always #10 clk = ~clk;

  stereo_ramp_vol dut_i (
    .clk(clk), .rst_n(rst_n), .fs_stb(fs_stb), .slow_ramp(slow_ramp),
    .vol_l(vol_l), .vol_r(vol_r), .in_l(in_l), .in_r(in_r),
    .out_l(out_l), .out_r(out_r), .out_vld(out_vld), .cur_l(cur_l), .cur_r(cur_r)
  );

  task automatic chk(input string req, input longint act, input longint exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  function automatic longint mant_e(input int r);
    return longint'($rtoi($pow(2.0, -r / 12.0) * 32768.0 + 0.5));
  endfunction

  function automatic longint expect_out(input longint x, input int c);
    longint p, s;
    if (c == 255) return 0;
    p = x * mant_e(c % 12);
    s = p >>> (11 + c / 12);
    if (s > 8388607) return 8388607;
    if (s < -8388608) return -8388608;
    return s;
  endfunction

  function automatic string tag_of(input longint x, input int c);
    longint p, s;
    if (c == 255) return "R2 mute";
    p = x * mant_e(c % 12);
    s = p >>> (11 + c / 12);
    if (s > 8388607 || s < -8388608) return "R3 clamp";
    return "R1 gain";
  endfunction

  function automatic int pat(input int k, input int ch);
    case ((k + ch) % 6)
      0: return 8388607;
      1: return -8388608;
      2: return 1000 + k * 37;
      3: return -((k * 9111) % 8388608);
      4: return 1;
      default: return -1;
    endcase
  endfunction

  task automatic model_step(input int ch, input int tgt);
    int iv;
    iv = slow_ramp ? 12 : 3;
    if (ecur[ch] == tgt) ecnt[ch] = 0;
    else if (ecnt[ch] >= iv - 1) begin
      ecnt[ch] = 0;
      ecur[ch] += (ecur[ch] < tgt) ? 1 : -1;
    end else ecnt[ch]++;
  endtask

  task automatic strobe();
    longint xl, xr, el, er;
    @(negedge clk);
    xl = pat(kidx, 0);
    xr = pat(kidx, 1);
    kidx++;
    in_l = 24'(xl);
    in_r = 24'(xr);
    fs_stb = 1'b1;
    el = expect_out(xl, ecur[0]);
    er = expect_out(xr, ecur[1]);
    model_step(0, int'(vol_l));
    model_step(1, int'(vol_r));
    @(negedge clk);
    fs_stb = 1'b0;
    chk(tag_of(xl, ecur[0] == 255 && el == 0 ? 255 : 0) == "" ? "R1" : (el == 0 && xl != 0 ? "R2 left" : "R1 left"), out_l, el);
    chk("R8 right sample", out_r, er);
    chk("R5 valid", out_vld, 1);
    chk("R6 R7 left code", cur_l, ecur[0]);
    chk("R6 R7 right code", cur_r, ecur[1]);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    total++;
    bad++;
    $display("FAIL watchdog expired act=running exp=finished");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    int hit;
    repeat (4) @(negedge clk);
    chk("R4 reset left code", cur_l, 48);
    chk("R4 reset right code", cur_r, 48);
    chk("R4 reset left out", out_l, 0);
    chk("R4 reset right out", out_r, 0);
    chk("R4 reset valid", out_vld, 0);
    ecur[0] = 48; ecur[1] = 48; ecnt[0] = 0; ecnt[1] = 0;
    rst_n = 1'b1;

    vol_l = 8'd0;
    vol_r = 8'd48;
    for (int i = 0; i < 150; i++) strobe();
    chk("R8 left reached 00h", cur_l, 0);
    chk("R8 right held", cur_r, 48);

    vol_l = 8'd255;
    vol_r = 8'd100;
    hit = -1;
    for (int i = 1; i <= 800; i++) begin
      strobe();
      if (hit < 0 && cur_l == 8'd255) hit = i;
    end
    chk("R7 full range strobes", hit, 765);
    chk("R7 within 912", (hit > 0 && hit <= 912) ? 1 : 0, 1);
    chk("R2 left muted out", out_l, 0);

    slow_ramp = 1'b1;
    vol_l = 8'd253;
    hit = -1;
    for (int i = 1; i <= 30; i++) begin
      strobe();
      if (hit < 0 && cur_l == 8'd254) hit = i;
    end
    chk("R7 slow first step", hit, 12);
    chk("R7 slow settled", cur_l, 253);

    slow_ramp = 1'b0;
    vol_l = 8'd200;
    for (int i = 0; i < 10; i++) strobe();
    chk("R9 mid ramp code", cur_l, 250);
    vol_l = 8'd255;
    for (int i = 0; i < 20; i++) strobe();
    chk("R9 turned back", cur_l, 255);

    vol_l = 8'd10;
    vol_r = 8'd0;
    repeat (20) @(negedge clk);
    chk("R5 idle valid low", out_vld, 0);
    chk("R5 idle left code", cur_l, 255);
    chk("R5 idle right code", cur_r, ecur[1]);
    chk("R5 idle out hold", out_l, 0);
    vol_l = 8'd255;
    vol_r = 8'd100;
    for (int i = 0; i < 12; i++) strobe();
    chk("R10 settled left", cur_l, 255);
    chk("R10 settled right", cur_r, 100);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule